// File: doc/BRIEF.md
# Byte-Lane Static RAM Model with Dual Chip Select

This block is a synthesizable model of a 16-bit static RAM whose pins are sampled on a system clock. It has two chip selects of opposite polarity, an active-low output enable, an active-low write enable, and one active-low enable per byte lane. On each rising clock edge it decodes the sampled control pins into one of four access modes: standby, output disabled, read, or write. In a write cycle it stores the enabled byte lanes. In a read cycle it returns the addressed word on the enabled lanes.

The outputs are registered. The result of the access sampled at one edge appears after that edge and stays until the next edge. Each byte lane has its own drive-enable output, so tristate pads can be wrapped around the block outside it. The data on a lane that is not driven is held at zero. The address port is 18 bits wide by default. The storage actually built holds 2**STORE_AW words (1024 by default), and address bits above that width are ignored.

Top module: `sram_byte_lane_model`

## Requirements
- R1: The sampled cycle is standby when `sel_n` is 1, or `sel` is 0, or both bits of `lane_en_n` are 1. In standby, `drive_en` is 0, `mode` is 0 and nothing is stored.
- R2: When selected with `wr_en_n` at 1 and `out_en_n` at 1, the block drives no lane (`drive_en` is 0) and reports `mode` 1.
- R3: When selected with `wr_en_n` at 1 and `out_en_n` at 0, the cycle is a read and `mode` is 2. `drive_en[i]` is the inverse of `lane_en_n[i]`, where bit 0 is data bits 7:0 and bit 1 is data bits 15:8.
- R4: When selected with `wr_en_n` at 0, the cycle is a write and `mode` is 3, whatever `out_en_n` is. Only the lanes whose `lane_en_n` bit is 0 take `wdata`, and `drive_en` stays 0.
- R5: A word is stored only in a sampled cycle where `sel_n` and `wr_en_n` are both 0 together. A cycle in which either of them is already 1 leaves the storage unchanged.
- R6: A read returns the word last stored at the address. Each lane that is not driven shows 0 on `rdata`. Every output changes one clock edge after the inputs are sampled.
- R7: While `rst_n` is 0, the next edge clears `drive_en`, `mode` and `rdata` to 0.
- R8: Only the low STORE_AW address bits (10 by default) select a word. Two addresses that differ only above those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| lane_en_n | input | LANES (2) | Active-low byte-lane enables; bit 0 is the low byte |
| addr | input | ADDR_W (18) | Word address |
| wdata | input | LANES*LANE_W (16) | Write data |
| rdata | output | LANES*LANE_W (16) | Read data; lanes that are not driven read 0 |
| drive_en | output | LANES (2) | Per-lane drive enable for outside tristate pads |
| mode | output | 2 | Access mode: 0 standby, 1 output disabled, 2 read, 3 write |

## Verification
The properties assume that each control pin holds a single clean 0 or 1 across every sampling edge, because the model sees only what is present at the edge. They also assume that reset is held for at least one edge before any access is judged. The stimulus changes all inputs only on the falling clock edge and holds reset low for several edges. Every pin combination the stimulus drives is a defined level, and this includes the don't-care pins, which are given each value in turn. The bench never reads an address that it has not written first, because the storage array starts with no defined contents.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_HOLD  = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_mode_e;

endpackage

// File: rtl/sram_access_decode.sv
module sram_access_decode
    import sram_lane_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel_n,
    input  logic             sel,
    input  logic             out_en_n,
    input  logic             wr_en_n,
    input  logic [LANES-1:0] lane_en_n,
    output acc_mode_e        acc_mode,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] lane_rd
);

    logic any_lane;
    logic chosen;

    always_comb begin
        any_lane = |(~lane_en_n);
        chosen   = !sel_n && sel && any_lane;
        acc_mode = ACC_IDLE;
        lane_wr  = '0;
        lane_rd  = '0;
        if (chosen) begin
            if (!wr_en_n) begin
                acc_mode = ACC_WRITE;
                lane_wr  = ~lane_en_n;
            end else if (!out_en_n) begin
                acc_mode = ACC_READ;
                lane_rd  = ~lane_en_n;
            end else begin
                acc_mode = ACC_HOLD;
            end
        end
    end

endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
    parameter int AW = 10,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          wr,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  wbyte,
    output logic [W-1:0]  rbyte
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];
    logic [W-1:0] rbyte_q;

    always_ff @(posedge clk) begin
        if (wr) begin
            cells[idx] <= wbyte;
        end
        rbyte_q <= cells[idx];
    end

    assign rbyte = rbyte_q;

endmodule

// File: rtl/sram_byte_lane_model.sv
module sram_byte_lane_model
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int STORE_AW = 10,
    parameter int LANE_W   = 8,
    parameter int LANES    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_n,
    input  logic                     sel,
    input  logic                     out_en_n,
    input  logic                     wr_en_n,
    input  logic [LANES-1:0]         lane_en_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic [LANES-1:0]         drive_en,
    output logic [1:0]               mode
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        acc_mode_e        acc;
        logic [LANES-1:0] drive;
    } out_regs_t;

    acc_mode_e        dec_mode;
    logic [LANES-1:0] dec_wr;
    logic [LANES-1:0] dec_rd;
    logic [STORE_AW-1:0] word_idx;
    logic [LANE_W-1:0]   lane_rbyte [LANES];

    out_regs_t regs_d;
    out_regs_t regs_q;

    assign word_idx = addr[STORE_AW-1:0];

    sram_access_decode #(
        .LANES(LANES)
    ) u_decode (
        .sel_n    (sel_n),
        .sel      (sel),
        .out_en_n (out_en_n),
        .wr_en_n  (wr_en_n),
        .lane_en_n(lane_en_n),
        .acc_mode (dec_mode),
        .lane_wr  (dec_wr),
        .lane_rd  (dec_rd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_store #(
            .AW(STORE_AW),
            .W (LANE_W)
        ) u_store (
            .clk  (clk),
            .wr   (dec_wr[g]),
            .idx  (word_idx),
            .wbyte(wdata[g*LANE_W +: LANE_W]),
            .rbyte(lane_rbyte[g])
        );

        assign rdata[g*LANE_W +: LANE_W] =
            regs_q.drive[g] ? lane_rbyte[g] : '0;
    end

    always_comb begin
        regs_d       = regs_q;
        regs_d.acc   = dec_mode;
        regs_d.drive = dec_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.acc   <= ACC_IDLE;
            regs_q.drive <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign drive_en = regs_q.drive;
    assign mode     = regs_q.acc;

    initial begin
        if (STORE_AW > ADDR_W) begin
            $error("STORE_AW must not exceed ADDR_W");
        end
        if (DATA_W != LANES * LANE_W) begin
            $error("data width mismatch");
        end
    end

endmodule

// File: rtl/sram_byte_lane_checker.sv
module sram_byte_lane_checker #(
    parameter int ADDR_W = 18,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sel_n,
    input logic                    sel,
    input logic                    out_en_n,
    input logic                    wr_en_n,
    input logic [LANES-1:0]        lane_en_n,
    input logic [LANES*LANE_W-1:0] rdata,
    input logic [LANES-1:0]        drive_en,
    input logic [1:0]              mode
);

    logic picked;
    logic [LANES*LANE_W-1:0] quiet_mask;

    assign picked = !sel_n && sel && (lane_en_n != '1);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            quiet_mask[i*LANE_W +: LANE_W] = drive_en[i] ? '0 : '1;
        end
    end

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !picked |=> (drive_en == '0 && mode == 2'd0)); // R1

    AST_OUTPUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (picked && wr_en_n && out_en_n) |=> (drive_en == '0 && mode == 2'd1)); // R2

    AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (picked && wr_en_n && !out_en_n) |=> (drive_en == ~$past(lane_en_n) && mode == 2'd2)); // R3

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (picked && !wr_en_n) |=> (drive_en == '0 && mode == 2'd3)); // R4

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & quiet_mask) == '0); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (drive_en == '0 && mode == 2'd0 && rdata == '0)); // R7

endmodule

bind sram_byte_lane_model sram_byte_lane_checker #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W),
    .LANES (LANES)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .sel      (sel),
    .out_en_n (out_en_n),
    .wr_en_n  (wr_en_n),
    .lane_en_n(lane_en_n),
    .rdata    (rdata),
    .drive_en (drive_en),
    .mode     (mode)
);

// File: tb/tb_sram_byte_lane_model.sv
module tb_sram_byte_lane_model;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 18;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_n;
    logic        sel;
    logic        out_en_n;
    logic        wr_en_n;
    logic [1:0]  lane_en_n;
    logic [17:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  drive_en;
    logic [1:0]  mode;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_byte_lane_model #(
        .ADDR_W(ADDR_W)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .sel      (sel),
        .out_en_n (out_en_n),
        .wr_en_n  (wr_en_n),
        .lane_en_n(lane_en_n),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .drive_en (drive_en),
        .mode     (mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one access, then sample after the following edge
    task automatic cycle(input logic s_n, input logic s, input logic o_n, input logic w_n,
                         input logic [1:0] ln, input logic [17:0] a, input logic [15:0] d);
        sel_n = s_n; sel = s; out_en_n = o_n; wr_en_n = w_n;
        lane_en_n = ln; addr = a; wdata = d;
        @(negedge clk);
    endtask

    task automatic read_word(input string tag, input logic [17:0] a, input logic [15:0] exp);
        cycle(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, a, 16'h0);
        check(tag, rdata, exp);
        check(tag, drive_en, 2'b11);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cycle(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 18'd0, 16'h0);
        cycle(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 18'd0, 16'h0);
        check("R7 drive_en in reset", drive_en, 2'b00);
        check("R7 mode in reset", mode, 2'd0);
        check("R7 rdata in reset", rdata, 16'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_word_rw();
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd7, 16'hBEEF);
        check("R4 word write mode", mode, 2'd3);
        read_word("R6 word read back", 18'd7, 16'hBEEF);
        check("R3 word read mode", mode, 2'd2);
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd8, 16'h0F0F);
        read_word("R6 second word", 18'd8, 16'h0F0F);
        read_word("R6 first word kept", 18'd7, 16'hBEEF);
    endtask

    task automatic t_byte_lanes();
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd30, 16'hA5C3);
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 18'd30, 16'hFF77);
        read_word("R4 low lane write only", 18'd30, 16'hA577);
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 18'd30, 16'h12EE);
        read_word("R4 high lane write only", 18'd30, 16'h1277);
        cycle(1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 18'd30, 16'h0);
        check("R3 low lane read data", rdata, 16'h0077);
        check("R3 low lane drive", drive_en, 2'b01);
        cycle(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 18'd30, 16'h0);
        check("R3 high lane read data", rdata, 16'h1200);
        check("R3 high lane drive", drive_en, 2'b10);
    endtask

    task automatic t_standby();
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd40, 16'h5555);
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 18'd40, 16'h1111);
        check("R1 sel_n high mode", mode, 2'd0);
        check("R1 sel_n high drive", drive_en, 2'b00);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 18'd40, 16'h2222);
        check("R1 sel low mode", mode, 2'd0);
        check("R1 sel low rdata", rdata, 16'h0);
        cycle(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 18'd40, 16'h3333);
        check("R1 no lane mode", mode, 2'd0);
        cycle(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 18'd40, 16'h0);
        check("R1 no lane read drive", drive_en, 2'b00);
        read_word("R1 standby stored nothing", 18'd40, 16'h5555);
    endtask

    task automatic t_out_off();
        cycle(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 18'd40, 16'h0);
        check("R2 output disabled mode", mode, 2'd1);
        check("R2 output disabled drive", drive_en, 2'b00);
        check("R2 output disabled rdata", rdata, 16'h0);
    endtask

    task automatic t_write_oe_low();
        cycle(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 18'd50, 16'hC0DE);
        check("R4 write with oe low mode", mode, 2'd3);
        check("R4 write with oe low drive", drive_en, 2'b00);
        check("R4 write with oe low rdata", rdata, 16'h0);
        read_word("R4 write with oe low stored", 18'd50, 16'hC0DE);
    endtask

    task automatic t_overlap();
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd60, 16'h1111);
        cycle(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 18'd60, 16'hDEAD);
        cycle(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 18'd60, 16'hBEAD);
        read_word("R5 no write outside overlap", 18'd60, 16'h1111);
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd60, 16'h2468);
        cycle(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 18'd60, 16'h9999);
        read_word("R5 write ends when we rises", 18'd60, 16'h2468);
    endtask

    task automatic t_alias();
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'h00005, 16'h7E57);
        read_word("R8 alias one step up", 18'h00405, 16'h7E57);
        read_word("R8 alias at top", 18'h3FC05, 16'h7E57);
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'h20005, 16'h4321);
        read_word("R8 aliased write overwrites", 18'h00005, 16'h4321);
    endtask

    task automatic t_latency();
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd70, 16'hAAAA);
        sel_n = 1'b0; sel = 1'b1; out_en_n = 1'b0; wr_en_n = 1'b1;
        lane_en_n = 2'b00; addr = 18'd70;
        @(posedge clk);
        #1;
        check("R6 read visible one edge later", rdata, 16'hAAAA);
        @(negedge clk);
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0);
        check("R6 drive drops after idle", drive_en, 2'b00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sel_n = 1'b1; sel = 1'b0; out_en_n = 1'b1; wr_en_n = 1'b1;
        lane_en_n = 2'b11; addr = '0; wdata = '0;
        @(negedge clk);
        t_reset();
        t_word_rw();
        t_byte_lanes();
        t_standby();
        t_out_off();
        t_write_oe_low();
        t_overlap();
        t_alias();
        t_latency();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule